// File: doc/BRIEF.md
# Proximity ID clone programming controller

This controller turns a 44-bit proximity card identifier into the four block writes that make a programmable low-frequency tag behave like a card carrying that identifier. The identifier arrives as a high part and a 32-bit low part. The high part is carried on a 16-bit input so that an identifier wider than 44 bits can be seen and refused. Every identifier bit is expanded into a two-bit pair: a one becomes 10 and a zero becomes 01. The pairs are packed into three 32-bit data words. The first of these words also carries a fixed preamble byte. A fourth, fixed configuration word completes the set. It selects a data rate of RF/50, FSK2a modulation and a maximum block count of three.

The controller hands the words one at a time to a downstream block-write sequencer, which handles the radio-level bit timing. Each write is a request carrying a data word and a block address. The request is held until the sequencer accepts it. The controller then waits for the sequencer's completion pulse before it presents the next write. After the last write completes, a one-cycle done pulse is raised. An identifier that is too wide produces a one-cycle error pulse and no writes at all.

The state machine has five states. IDLE waits for a start strobe. REJECT raises the error pulse. REQ presents a write. WAIT holds until the sequencer reports completion. FIN raises the done pulse. The transitions are as follows. IDLE goes to REJECT on a start with a high part above 0xFFF, and to REQ on a start with a legal high part. REJECT returns to IDLE. REQ goes to WAIT on accept. WAIT goes to REQ on completion while writes remain, and to FIN on the completion of the last write. FIN returns to IDLE.

Top module: `clone_prog_ctrl`

## Requirements
- R1: After reset the outputs wr_req_o, done_o and err_o are all low.
- R2: A start strobe with id_hi_i greater than 0xFFF raises err_o for exactly one cycle, in the cycle after the strobe is sampled. No write request follows and done_o stays low.
- R3: Each identifier bit is expanded into a pair of bits: a 1 becomes 10 and a 0 becomes 01. A higher-numbered source bit always lands in a higher pair.
- R4: The word for block 1 has 0x1D in bits 31:24. Bits 23:0 hold the 12 bits id_hi_i[11:0], expanded, with id_hi_i[11] in bits 23:22.
- R5: The word for block 2 holds id_lo_i[31:16], expanded, with id_lo_i[31] in bits 31:30. The word for block 3 holds id_lo_i[15:0], expanded, with id_lo_i[15] in bits 31:30.
- R6: An accepted identifier produces exactly four writes, in this order: block 1, block 2 and block 3, then block 0 with the word 0x00107060 (RF/50, FSK2a, maximum block 3). A high part of exactly 0xFFF is accepted.
- R7: wr_req_o stays high, with wr_data_o and wr_addr_o unchanged, until a cycle in which wr_ack_i is high. A write counts as accepted in the cycle where wr_req_o and wr_ack_i are both high.
- R8: After an accepted write, wr_req_o stays low until the sequencer's wr_done_i pulse has been sampled. The next request appears in the cycle after that pulse.
- R9: done_o is high for exactly one cycle, in the cycle after wr_done_i is sampled for the block 0 write, and at no other time.
- R10: A start strobe that arrives while a programming run, its done cycle or an error cycle is in progress has no effect: no extra writes, no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled in IDLE only |
| id_hi_i | input | 16 | High part of the identifier; only bits 11:0 are legal |
| id_lo_i | input | 32 | Low part of the identifier |
| wr_ack_i | input | 1 | Sequencer accepts the presented write |
| wr_done_i | input | 1 | Sequencer completion pulse for the accepted write |
| wr_req_o | output | 1 | Write request, held until accepted |
| wr_data_o | output | 32 | Data word of the presented write |
| wr_addr_o | output | 3 | Block address of the presented write |
| err_o | output | 1 | One-cycle pulse when an identifier is refused |
| done_o | output | 1 | One-cycle pulse after the block 0 write completes |

## Verification
Two events can fall in the same cycle: the sequencer's completion pulse for the block 0 write, and a new start strobe. The bench raises both in one cycle, and in a second run raises the strobe during the done cycle itself. It then expects exactly one done pulse, with no further request and no error in the cycles that follow. A scoreboard holds the expected address and data of each write. Any request that appears with no expected entry, or that appears while the sequencer is still busy, is reported as a failure.

// File: rtl/clone_pkg.sv
package clone_pkg;
    localparam int ID_HI_W   = 12;
    localparam int HI_IN_W   = 16;
    localparam int ID_LO_W   = 32;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int NUM_WR    = 4;
    localparam int IDX_W     = $clog2(NUM_WR);
    localparam int HALF_W    = ID_LO_W / 2;
    localparam logic [7:0]        PREAMBLE = 8'h1D;
    localparam logic [WORD_W-1:0] CFG_WORD = 32'h0010_7060;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REJECT,
        ST_REQ,
        ST_WAIT,
        ST_FIN
    } ctrl_state_t;
endpackage

// File: rtl/pair_expander.sv
module pair_expander #(
    parameter int N = 16
) (
    input  logic [N-1:0]   bits_i,
    output logic [2*N-1:0] pairs_o
);
    for (genvar g = 0; g < N; g++) begin : g_pair
        assign pairs_o[2*g+1] = bits_i[g];
        assign pairs_o[2*g]   = ~bits_i[g];
    end
endmodule

// File: rtl/clone_word_builder.sv
module clone_word_builder
    import clone_pkg::*;
(
    input  logic [ID_HI_W-1:0] hi_i,
    input  logic [ID_LO_W-1:0] lo_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [WORD_W-1:0]  word_o,
    output logic [ADDR_W-1:0]  addr_o
);
    logic [2*ID_HI_W-1:0] hi_pairs;
    logic [2*HALF_W-1:0]  up_pairs;
    logic [2*HALF_W-1:0]  dn_pairs;

    pair_expander #(.N(ID_HI_W)) u_hi (
        .bits_i (hi_i),
        .pairs_o(hi_pairs)
    );
    pair_expander #(.N(HALF_W)) u_up (
        .bits_i (lo_i[ID_LO_W-1:HALF_W]),
        .pairs_o(up_pairs)
    );
    pair_expander #(.N(HALF_W)) u_dn (
        .bits_i (lo_i[HALF_W-1:0]),
        .pairs_o(dn_pairs)
    );

    always_comb begin
        unique case (idx_i)
            2'd0: begin
                word_o = {PREAMBLE, hi_pairs};
                addr_o = 3'd1;
            end
            2'd1: begin
                word_o = up_pairs;
                addr_o = 3'd2;
            end
            2'd2: begin
                word_o = dn_pairs;
                addr_o = 3'd3;
            end
            default: begin
                word_o = CFG_WORD;
                addr_o = 3'd0;
            end
        endcase
    end
endmodule

// File: rtl/clone_ctrl_fsm.sv
module clone_ctrl_fsm
    import clone_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             id_bad_i,
    input  logic             wr_ack_i,
    input  logic             wr_done_i,
    output logic             load_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             wr_req_o,
    output logic             err_o,
    output logic             done_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WR - 1);

    ctrl_state_t state, state_nx;
    logic [IDX_W-1:0] idx_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start_i) state_nx = id_bad_i ? ST_REJECT : ST_REQ;
            ST_REJECT: state_nx = ST_IDLE;
            ST_REQ:    if (wr_ack_i) state_nx = ST_WAIT;
            ST_WAIT:   if (wr_done_i) state_nx = (idx_q == LAST_IDX) ? ST_FIN : ST_REQ;
            ST_FIN:    state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start_i)
                idx_q <= '0;
            else if (state == ST_WAIT && wr_done_i && idx_q != LAST_IDX)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        load_o   = (state == ST_IDLE) && start_i && !id_bad_i;
        wr_req_o = (state == ST_REQ);
        err_o    = (state == ST_REJECT);
        done_o   = (state == ST_FIN);
        idx_o    = idx_q;
    end

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R2
    err_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (!wr_req_o && !err_o));
    // R8
    req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req_o) && !$past(start_i) |-> $past(wr_done_i));
endmodule

// File: rtl/clone_prog_ctrl.sv
module clone_prog_ctrl
    import clone_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [HI_IN_W-1:0] id_hi_i,
    input  logic [ID_LO_W-1:0] id_lo_i,
    input  logic               wr_ack_i,
    input  logic               wr_done_i,
    output logic               wr_req_o,
    output logic [WORD_W-1:0]  wr_data_o,
    output logic [ADDR_W-1:0]  wr_addr_o,
    output logic               err_o,
    output logic               done_o
);
    logic               id_bad;
    logic               load;
    logic [IDX_W-1:0]   idx;
    logic [ID_HI_W-1:0] hi_q;
    logic [ID_LO_W-1:0] lo_q;

    assign id_bad = (id_hi_i >> ID_HI_W) != '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= id_hi_i[ID_HI_W-1:0];
            lo_q <= id_lo_i;
        end
    end

    clone_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .id_bad_i (id_bad),
        .wr_ack_i (wr_ack_i),
        .wr_done_i(wr_done_i),
        .load_o   (load),
        .idx_o    (idx),
        .wr_req_o (wr_req_o),
        .err_o    (err_o),
        .done_o   (done_o)
    );

    clone_word_builder u_build (
        .hi_i  (hi_q),
        .lo_i  (lo_q),
        .idx_i (idx),
        .word_o(wr_data_o),
        .addr_o(wr_addr_o)
    );

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_data_o) && $stable(wr_addr_o)));
    // R6
    last_is_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_addr_o) == 3'd0 && $past(wr_data_o) == CFG_WORD));
endmodule

// File: tb/clone_prog_ctrl_bench.sv
module clone_prog_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  a;
        logic [31:0] d;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_i = 0;
    logic [15:0] id_hi_i = 0;
    logic [31:0] id_lo_i = 0;
    logic        wr_ack_i = 0;
    logic        wr_done_i = 0;
    logic        wr_req_o, err_o, done_o;
    logic [31:0] wr_data_o;
    logic [2:0]  wr_addr_o;

    item_t exp_q[$];
    int checks = 0, fails = 0;
    int done_cnt = 0, req_cnt = 0;
    int ack_dly = 0, done_dly = 1;
    int collide = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clone_prog_ctrl u_clone_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .id_hi_i(id_hi_i),
        .id_lo_i(id_lo_i), .wr_ack_i(wr_ack_i), .wr_done_i(wr_done_i),
        .wr_req_o(wr_req_o), .wr_data_o(wr_data_o), .wr_addr_o(wr_addr_o),
        .err_o(err_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expand16(input logic [15:0] v);
        logic [31:0] r;
        for (int i = 0; i < 16; i++) r[2*i +: 2] = v[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    task automatic push_id(input logic [15:0] hi, input logic [31:0] lo);
        item_t it;
        it.a = 3'd1; it.d = {8'h1D, expand16({4'h0, hi[11:0]})[23:0]}; exp_q.push_back(it);
        it.a = 3'd2; it.d = expand16(lo[31:16]); exp_q.push_back(it);
        it.a = 3'd3; it.d = expand16(lo[15:0]);  exp_q.push_back(it);
        it.a = 3'd0; it.d = 32'h0010_7060;       exp_q.push_back(it);
    endtask

    always @(negedge clk) if (done_o) done_cnt++;

    // sequencer model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && wr_req_o) begin
                item_t seen, ex;
                req_cnt++;
                seen.a = wr_addr_o; seen.d = wr_data_o;
                for (int k = 0; k < ack_dly; k++) begin
                    @(negedge clk);
                    chk(wr_req_o && wr_data_o == seen.d && wr_addr_o == seen.a,
                        "R7 hold", wr_data_o, seen.d);
                end
                chk(exp_q.size() > 0, "R10 unexpected write", {29'd0, seen.a}, 32'd0);
                if (exp_q.size() > 0) begin
                    ex = exp_q.pop_front();
                    chk(seen.a == ex.a, "R6 address order", {29'd0, seen.a}, {29'd0, ex.a});
                    chk(seen.d == ex.d, (ex.a == 3'd1) ? "R4 block1" :
                        (ex.a == 3'd0) ? "R6 config" : "R5 data block", seen.d, ex.d);
                end
                wr_ack_i = 1;
                @(negedge clk);
                wr_ack_i = 0;
                for (int k = 0; k < done_dly; k++) begin
                    chk(!wr_req_o, "R8 req before done", {31'd0, wr_req_o}, 32'd0);
                    @(negedge clk);
                end
                wr_done_i = 1;
                if (collide == 1 && seen.a == 3'd0) start_i = 1;
                @(negedge clk);
                wr_done_i = 0;
                start_i = 0;
                chk(done_o == (seen.a == 3'd0), "R9 done timing", {31'd0, done_o},
                    {31'd0, seen.a == 3'd0});
                if (collide == 2 && done_o) begin
                    start_i = 1;
                    @(negedge clk);
                    start_i = 0;
                end
            end
        end
    end

    task automatic pulse_start;
        @(negedge clk); start_i = 1;
        @(negedge clk); start_i = 0;
    endtask

    task automatic run_ok(input logic [15:0] hi, input logic [31:0] lo);
        int d0;
        d0 = done_cnt;
        push_id(hi, lo);
        id_hi_i = hi; id_lo_i = lo;
        pulse_start();
        id_hi_i = 16'hFFFF; id_lo_i = ~lo;   // captured values must persist
        while (done_cnt == d0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9 single done", done_cnt, d0 + 1);
        chk(exp_q.size() == 0, "R6 four writes", exp_q.size(), 0);
        chk(!err_o, "R2 no err on good id", {31'd0, err_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!wr_req_o && !done_o && !err_o, "R1 reset outputs",
            {29'd0, wr_req_o, done_o, err_o}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        chk(!wr_req_o && !done_o && !err_o, "R1 idle outputs",
            {29'd0, wr_req_o, done_o, err_o}, 32'd0);

        // R3 R4 R5: all-zero and all-one patterns
        run_ok(16'h0000, 32'h0000_0000);
        ack_dly = 2; done_dly = 3;
        run_ok(16'h0FFF, 32'hFFFF_FFFF);   // R6 boundary 0xFFF accepted
        ack_dly = 1; done_dly = 0;
        run_ok(16'h0A5C, 32'h8001_C3E7);   // R3 bit ordering
        ack_dly = 3; done_dly = 2;
        run_ok(16'h0123, 32'h1234_ABCD);

        // R2 rejection
        begin
            int r0, d0;
            r0 = req_cnt; d0 = done_cnt;
            id_hi_i = 16'h1000; id_lo_i = 32'h5555_0000;
            @(negedge clk); start_i = 1;
            @(negedge clk); start_i = 0;
            chk(err_o, "R2 err pulse", {31'd0, err_o}, 32'd1);
            start_i = 1;                    // R10 start during error cycle
            @(negedge clk); start_i = 0;
            chk(!err_o, "R2 err one cycle", {31'd0, err_o}, 32'd0);
            repeat (8) @(negedge clk);
            chk(req_cnt == r0, "R2 no writes", req_cnt, r0);
            chk(done_cnt == d0, "R2 no done", done_cnt, d0);
            chk(!err_o, "R10 start in error cycle ignored", {31'd0, err_o}, 32'd0);
        end

        // R10 start in the middle of a run
        ack_dly = 1; done_dly = 2;
        fork
            run_ok(16'h0F0F, 32'hDEAD_BEEF);
            begin
                repeat (6) @(negedge clk);
                id_hi_i = 16'h0001; id_lo_i = 32'h0;
                start_i = 1; @(negedge clk); start_i = 0;
            end
        join

        // R10 start coincides with final completion pulse
        collide = 1;
        run_ok(16'h0777, 32'h0F0F_F0F0);
        // R10 start during the done cycle
        collide = 2;
        run_ok(16'h0800, 32'h0000_0001);
        collide = 0;
        begin
            int r0;
            r0 = req_cnt;
            repeat (10) @(negedge clk);
            chk(req_cnt == r0 && !wr_req_o, "R10 no extra run", req_cnt, r0);
        end

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(negedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog R1 actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule